// File: doc/BRIEF.md
# RAM Nibble Bit Operation Unit

This unit sits between a processor core and a small data RAM that stores 4-bit words. It performs six operations on the word at one RAM address. It can set or clear a single bit and write the word back. It can test a single bit and report the result to the core's status flip-flop. It can swap a register value with the RAM word and return the old contents. It also performs a plain read and a plain write. The core supplies the operation code, the bit number, the address and the register value in one cycle by raising `op_valid`. From then on the unit sequences the RAM alone: a read phase, an optional write phase, and a one-cycle `done` pulse at the end.

The RAM is synchronous. A read strobe in one cycle returns data on `ram_rdata` in the next cycle. The unit registers every operand when it accepts an operation. The RAM address therefore stays fixed for the whole operation, and the core is free to change its inputs at once. Any request that arrives while an operation is in progress is ignored.

Top module: `nibble_bitop_unit`

## Requirements
- R1: `bit_sel` picks one bit of the 4-bit word: value 0 is the least significant bit and value 3 the most significant.
- R2: Set (code 2) writes the addressed word back once, with the selected bit forced to 1 and the other three bits unchanged. `done` pulses 3 cycles after the request is accepted.
- R3: Clear (code 3) writes the addressed word back once, with the selected bit forced to 0 and the other three bits unchanged. `done` pulses 3 cycles after acceptance.
- R4: Test (code 4) performs one read and no write. `stat_strobe` pulses together with `done`, 2 cycles after acceptance. `stat_bit` equals the selected bit of the word that was read and holds that value until the next test.
- R5: Exchange (code 5) reads the word and then writes `reg_wdata` into it. `done` pulses 3 cycles after acceptance, and at that time `rd_data` shows the contents from before the write.
- R6: Read (code 0) performs one read and no write. `done` pulses 2 cycles after acceptance, with the word on `rd_data`.
- R7: Write (code 1) performs one write of `reg_wdata` and no read. `done` pulses 1 cycle after acceptance.
- R8: `ram_re` and `ram_we` are never high together. Every strobe of an operation carries the address that was accepted with the request.
- R9: `op_valid` is ignored while `busy` is high. Codes 6 and 7 are ignored and start no RAM access.
- R10: While reset is applied, `done`, `stat_strobe`, `busy`, `ram_re` and `ram_we` are low.
- R11: `done` and `stat_strobe` last exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Request strobe, taken only while idle |
| op_code | input | 3 | 0 read, 1 write, 2 set, 3 clear, 4 test, 5 exchange |
| bit_sel | input | 2 | Bit number for set, clear and test |
| addr | input | 4 | RAM word address |
| reg_wdata | input | 4 | Register value for write and exchange |
| ram_re | output | 1 | RAM read strobe |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 4 | RAM address, held for the whole operation |
| ram_wdata | output | 4 | RAM write data |
| ram_rdata | input | 4 | RAM read data, valid the cycle after `ram_re` |
| rd_data | output | 4 | Word captured in the read phase |
| stat_strobe | output | 1 | Status update pulse for test |
| stat_bit | output | 1 | Tested bit value |
| done | output | 1 | End-of-operation pulse |
| busy | output | 1 | Operation in progress |

## Verification
Counted from the clock edge that accepts a request, `done` is due after 1 cycle for a write, after 2 for a read or a test, and after 3 for set, clear or exchange. `stat_strobe` and `rd_data` are due in the same cycle as `done`. The bench drives every request half a cycle before the accepting edge. It then steps one cycle at a time, sampling at the falling edge, and checks that the first cycle with `done` high is exactly the one due for that operation. Only at that point does it compare `rd_data`, the status outputs, the number of RAM strobes seen since the request, and the bench RAM contents against its own model.

// File: rtl/nbu_pkg.sv
package nbu_pkg;

  localparam logic [2:0] OP_READ  = 3'd0;
  localparam logic [2:0] OP_WRITE = 3'd1;
  localparam logic [2:0] OP_SET   = 3'd2;
  localparam logic [2:0] OP_CLR   = 3'd3;
  localparam logic [2:0] OP_TEST  = 3'd4;
  localparam logic [2:0] OP_XCHG  = 3'd5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_CAP  = 2'd2,
    ST_WR   = 2'd3
  } nbu_state_e;

  function automatic logic op_known(input logic [2:0] code);
    return code <= OP_XCHG;
  endfunction

  function automatic logic op_ends_after_read(input logic [2:0] code);
    return (code == OP_READ) || (code == OP_TEST);
  endfunction

endpackage

// File: rtl/nbu_bitsel.sv
module nbu_bitsel #(
  parameter int DW = 4,
  localparam int BW = $clog2(DW)
) (
  input  logic [BW-1:0] sel,
  input  logic [DW-1:0] word,
  output logic [DW-1:0] mask,
  output logic          bit_o
);

  for (genvar g = 0; g < DW; g++) begin : g_mask
    assign mask[g] = (sel == BW'(g));
  end

  assign bit_o = word[sel];

endmodule

// File: rtl/nbu_modify.sv
module nbu_modify
  import nbu_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic [2:0]    op,
  input  logic [DW-1:0] word,
  input  logic [DW-1:0] mask,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] word_o
);

  always_comb begin
    unique case (op)
      OP_SET:  word_o = word | mask;
      OP_CLR:  word_o = word & ~mask;
      default: word_o = wdata;
    endcase
  end

endmodule

// File: rtl/nbu_ctrl.sv
module nbu_ctrl
  import nbu_pkg::*;
#(
  parameter int DW = 4,
  parameter int AW = 4,
  localparam int BW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [2:0]    op_code,
  input  logic [BW-1:0] bit_sel,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] ram_rdata,
  input  logic          test_bit,
  output logic [2:0]    op_q,
  output logic [BW-1:0] sel_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] word_q,
  output logic [AW-1:0] ram_addr,
  output logic          ram_re,
  output logic          ram_we,
  output logic          done,
  output logic          stat_strobe,
  output logic          stat_bit,
  output logic          busy
);

  nbu_state_e    state_q, state_d;
  logic          accept, cap_en, fin, test_cap;
  logic [AW-1:0] addr_q;
  logic          done_q, stb_q, sbit_q;

  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    cap_en  = 1'b0;
    fin     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (op_valid && op_known(op_code)) begin
          accept  = 1'b1;
          state_d = (op_code == OP_WRITE) ? ST_WR : ST_RD;
        end
      end
      ST_RD: state_d = ST_CAP;
      ST_CAP: begin
        cap_en = 1'b1;
        if (op_ends_after_read(op_q)) begin
          fin     = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_WR;
        end
      end
      ST_WR: begin
        fin     = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign test_cap = cap_en && (op_q == OP_TEST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
      stb_q   <= test_cap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_READ;
      sel_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      op_q    <= op_code;
      sel_q   <= bit_sel;
      addr_q  <= addr;
      wdata_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (cap_en) begin
      word_q <= ram_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sbit_q <= 1'b0;
    end else if (test_cap) begin
      sbit_q <= test_bit;
    end
  end

  assign ram_re      = (state_q == ST_RD);
  assign ram_we      = (state_q == ST_WR);
  assign ram_addr    = addr_q;
  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign stat_strobe = stb_q;
  assign stat_bit    = sbit_q;

  a_r8_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_re && ram_we));

  a_r8_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ram_addr));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r4_strobe_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    stat_strobe |-> done);

  a_r7_write_skips_read: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && op_q == OP_WRITE) |-> !$past(ram_re));

  a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ram_re && !ram_we);

endmodule

// File: rtl/nibble_bitop_unit.sv
module nibble_bitop_unit
  import nbu_pkg::*;
#(
  parameter int DW = 4,
  parameter int AW = 4,
  localparam int BW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [2:0]    op_code,
  input  logic [BW-1:0] bit_sel,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] reg_wdata,
  output logic          ram_re,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata,
  output logic [DW-1:0] rd_data,
  output logic          stat_strobe,
  output logic          stat_bit,
  output logic          done,
  output logic          busy
);

  logic [1:0]    rst_pipe;
  logic          rst_sync_n;
  logic [2:0]    op_q;
  logic [BW-1:0] sel_q;
  logic [DW-1:0] wdata_q, word_q, mask, read_mask;
  logic          test_bit, word_bit_unused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  nbu_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .op_valid    (op_valid),
    .op_code     (op_code),
    .bit_sel     (bit_sel),
    .addr        (addr),
    .reg_wdata   (reg_wdata),
    .ram_rdata   (ram_rdata),
    .test_bit    (test_bit),
    .op_q        (op_q),
    .sel_q       (sel_q),
    .wdata_q     (wdata_q),
    .word_q      (word_q),
    .ram_addr    (ram_addr),
    .ram_re      (ram_re),
    .ram_we      (ram_we),
    .done        (done),
    .stat_strobe (stat_strobe),
    .stat_bit    (stat_bit),
    .busy        (busy)
  );

  nbu_bitsel #(.DW(DW)) u_sel_word (
    .sel   (sel_q),
    .word  (word_q),
    .mask  (mask),
    .bit_o (word_bit_unused)
  );

  nbu_bitsel #(.DW(DW)) u_sel_read (
    .sel   (sel_q),
    .word  (ram_rdata),
    .mask  (read_mask),
    .bit_o (test_bit)
  );

  nbu_modify #(.DW(DW)) u_modify (
    .op     (op_q),
    .word   (word_q),
    .mask   (mask),
    .wdata  (wdata_q),
    .word_o (ram_wdata)
  );

  assign rd_data = word_q;

  a_r2_others_kept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ram_we && (op_q == OP_SET || op_q == OP_CLR)) |->
      (((ram_wdata ^ word_q) & ~mask) == '0));

  a_r2_bit_forced_high: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ram_we && op_q == OP_SET) |-> ((ram_wdata & mask) != '0));

  a_r3_bit_forced_low: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ram_we && op_q == OP_CLR) |-> ((ram_wdata & mask) == '0));

  a_r1_mask_onehot: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy |-> ($onehot0(read_mask) && (read_mask == mask)));

  a_r10_quiet_in_reset: assert property (@(posedge clk)
    !rst_sync_n |-> !(done || stat_strobe || busy || ram_re || ram_we));

endmodule

// File: tb/nibble_bitop_unit_bench.sv
module nibble_bitop_unit_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid;
  logic [2:0] op_code;
  logic [1:0] bit_sel;
  logic [3:0] addr, reg_wdata;
  logic       ram_re, ram_we;
  logic [3:0] ram_addr, ram_wdata, ram_rdata, rd_data;
  logic       stat_strobe, stat_bit, done, busy;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [3:0] mem [16];
  logic [3:0] exp_mem [16];
  int re_cnt = 0, we_cnt = 0, addr_err = 0;
  logic [3:0] cur_addr = '0;

  always #5 clk = ~clk;

  nibble_bitop_unit u_nibble_bitop_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .bit_sel(bit_sel), .addr(addr), .reg_wdata(reg_wdata),
    .ram_re(ram_re), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .rd_data(rd_data),
    .stat_strobe(stat_strobe), .stat_bit(stat_bit), .done(done), .busy(busy)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 4'((i * 7 + 3) & 15);
    end else begin
      if (ram_re) ram_rdata <= mem[ram_addr];
      if (ram_we) mem[ram_addr] <= ram_wdata;
    end
    if (ram_re) re_cnt <= re_cnt + 1;
    if (ram_we) we_cnt <= we_cnt + 1;
    if ((ram_re || ram_we) && ram_addr != cur_addr) addr_err <= addr_err + 1;
  end

  function automatic logic [3:0] f_set(input logic [3:0] w, input logic [1:0] b);
    return w | (4'b0001 << b);
  endfunction
  function automatic logic [3:0] f_clr(input logic [3:0] w, input logic [1:0] b);
    return w & ~(4'b0001 << b);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic [3:0] a,
                       input logic [1:0] b, input logic [3:0] wd, input bit intrude);
    int lat, exp_lat, re0, we0, ae0, exp_re, exp_we;
    logic [3:0] old, nxt, other;
    string req;
    old = exp_mem[a];
    other = exp_mem[a ^ 4'd1];
    case (op)
      3'd0: begin req = "R6"; exp_lat = 2; exp_re = 1; exp_we = 0; nxt = old; end
      3'd1: begin req = "R7"; exp_lat = 1; exp_re = 0; exp_we = 1; nxt = wd; end
      3'd2: begin req = "R2"; exp_lat = 3; exp_re = 1; exp_we = 1; nxt = f_set(old, b); end
      3'd3: begin req = "R3"; exp_lat = 3; exp_re = 1; exp_we = 1; nxt = f_clr(old, b); end
      3'd4: begin req = "R4"; exp_lat = 2; exp_re = 1; exp_we = 0; nxt = old; end
      default: begin req = "R5"; exp_lat = 3; exp_re = 1; exp_we = 1; nxt = wd; end
    endcase
    @(negedge clk);
    re0 = re_cnt; we0 = we_cnt; ae0 = addr_err;
    cur_addr = a;
    op_valid = 1'b1; op_code = op; bit_sel = b; addr = a; reg_wdata = wd;
    @(negedge clk);
    op_valid = 1'b0;
    lat = 0;
    while (!done && lat < 8) begin
      @(negedge clk);
      lat++;
      if (intrude && lat == 1) begin
        op_valid = 1'b1; op_code = 3'd1; addr = a ^ 4'd1; reg_wdata = ~other;
      end else begin
        op_valid = 1'b0;
      end
    end
    op_valid = 1'b0;
    chk(lat == exp_lat, {req, " done latency"}, lat, exp_lat);
    chk(re_cnt - re0 == exp_re, {req, " read strobes"}, re_cnt - re0, exp_re);
    chk(we_cnt - we0 == exp_we, {req, " write strobes"}, we_cnt - we0, exp_we);
    chk(addr_err == ae0, "R8 strobe address", addr_err - ae0, 0);
    chk(stat_strobe == (op == 3'd4), "R4 status strobe", int'(stat_strobe), int'(op == 3'd4));
    if (op == 3'd4)
      chk(stat_bit == old[b], "R4 R1 tested bit", int'(stat_bit), int'(old[b]));
    if (op == 3'd0 || op == 3'd5)
      chk(rd_data == old, {req, " returned old word"}, int'(rd_data), int'(old));
    exp_mem[a] = nxt;
    @(negedge clk);
    chk(!done && !stat_strobe, "R11 single-cycle pulse", int'(done), 0);
    chk(mem[a] == nxt, {req, " R1 stored word"}, int'(mem[a]), int'(nxt));
    if (intrude)
      chk(mem[a ^ 4'd1] == other, "R9 request while busy ignored",
          int'(mem[a ^ 4'd1]), int'(other));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed_discard;
    for (int i = 0; i < 16; i++) exp_mem[i] = 4'((i * 7 + 3) & 15);
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; bit_sel = '0; addr = '0; reg_wdata = '0;
    repeat (5) @(negedge clk);
    chk(!done && !busy && !stat_strobe && !ram_re && !ram_we, "R10 reset quiet",
        int'({done, busy, stat_strobe, ram_re, ram_we}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done, "R10 idle after reset", int'(busy), 0);

    // R1 R2 R3: every bit position, set from zero and clear from all ones
    for (int b = 0; b < 4; b++) begin
      do_op(3'd1, 4'd2, 2'(b), 4'h0, 1'b0);
      do_op(3'd2, 4'd2, 2'(b), 4'h0, 1'b0);
      do_op(3'd1, 4'd3, 2'(b), 4'hF, 1'b0);
      do_op(3'd3, 4'd3, 2'(b), 4'h0, 1'b0);
    end
    // R4: test each bit of 0101
    do_op(3'd1, 4'd4, 2'd0, 4'h5, 1'b0);
    for (int b = 0; b < 4; b++) do_op(3'd4, 4'd4, 2'(b), 4'h0, 1'b0);
    // R5 R6: exchange returns pre-write word, then read it back
    do_op(3'd5, 4'd4, 2'd0, 4'hA, 1'b0);
    do_op(3'd0, 4'd4, 2'd0, 4'h0, 1'b0);
    // R9: intruding request during set, test, exchange
    do_op(3'd2, 4'd6, 2'd1, 4'h0, 1'b1);
    do_op(3'd4, 4'd8, 2'd3, 4'h0, 1'b1);
    do_op(3'd5, 4'd10, 2'd0, 4'h7, 1'b1);
    // R9: codes 6 and 7 are ignored
    for (int c = 6; c < 8; c++) begin
      int re0, we0, dn;
      @(negedge clk);
      re0 = re_cnt; we0 = we_cnt; dn = 0;
      op_valid = 1'b1; op_code = 3'(c); addr = 4'd1; reg_wdata = 4'h0;
      @(negedge clk);
      op_valid = 1'b0;
      for (int k = 0; k < 4; k++) begin
        if (done || busy) dn++;
        @(negedge clk);
      end
      chk(dn == 0 && re_cnt == re0 && we_cnt == we0, "R9 undefined code ignored",
          dn + re_cnt - re0 + we_cnt - we0, 0);
    end

    seed_discard = int'($urandom(32'd20240611));
    for (int n = 0; n < 300; n++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 5));
      do_op(op, 4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)),
            4'($urandom_range(0, 15)), bit'($urandom_range(0, 3) == 0 && op != 3'd1));
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule